// File: doc/BRIEF.md
# Eight-Pin General-Purpose I/O Port with Digital-Input Gating

This block is the register side of one general-purpose I/O port. It keeps, per pin, a direction bit, an output data bit and a digital-input enable bit, and it turns them into a simple pad model: an output value and an active-high output enable for each pin. The pad input levels pass through a two-stage synchronizer before a CPU read can see them.

The CPU reaches four registers through a plain register interface: a 3-bit offset, a write strobe with write data, and a read strobe. Read data is registered and appears one cycle after the read strobe. The offsets are: 0 for pin levels, 1 for the output data bits, 2 for direction and 3 for digital-input enables. A write to offset 0 stores nothing of its own and updates the output data bits instead. Read-modify-write on offset 1 is therefore safe. The same sequence on offset 0 can change an output, because offset 0 returns pad levels rather than stored values.

A parameter mask marks the pins that can also carry analog signals. Such a pin reads as 0 at offset 0 until its digital-input enable bit is set. Those bits all come out of reset cleared. Pins outside the mask always have a live digital input, and their enable bits read back as 0.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset the direction bits are all 1, the output data bits are all 0, the digital-input enable bits are all 0, every pad output enable is 0 and the read data is 0.
- R2: A write to offset 2 sets the direction bits. In the following cycle, each pin whose direction bit is 0 has its pad output enable at 1, and each pin whose direction bit is 1 has it at 0.
- R3: A write to offset 1 stores the output data bits. In the following cycle the pad output value equals them, and a read of offset 1 returns them.
- R4: A write to offset 0 updates the output data bits exactly as a write to offset 1 would. A read of offset 0 returns pin levels, not the stored output data.
- R5: For a pin inside the analog mask whose digital-input enable bit is 0, a read of offset 0 returns 0 in that bit position whatever its pad level.
- R6: A read of offset 0 returns the synchronized pad level for every pin outside the analog mask, and for every pin inside it whose enable bit is 1.
- R7: A read of offset 3 returns the written enable bits for pins inside the analog mask and 0 for all other bit positions.
- R8: A pad change made just before rising edge k is first returned by an offset-0 read captured at edge k+2. Reads captured at edges k and k+1 still return the old level.
- R9: Reads of offsets 4 to 7 return 0. Writes to those offsets change no register and no pad output.
- R10: Read data is captured at the rising edge where the read strobe is high. It holds its value through cycles with the read strobe low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_addr_i | input | 3 | Register offset |
| reg_we_i | input | 1 | Write strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_re_i | input | 1 | Read strobe |
| reg_rdata_o | output | 8 | Registered read data |
| pad_in_i | input | 8 | Pad input levels, asynchronous |
| pad_out_o | output | 8 | Pad output values |
| pad_oe_o | output | 8 | Pad output enables, 1 drives |

## Verification
The assertions assume that writes and reads are single-cycle strobes with a defined offset. They also assume that pad inputs are free to change at any time, because the properties on port reads hold whatever the pad level is. The bench drives the strobes and pad levels only at falling edges. It holds each pad pattern steady for at least two rising edges before judging a port read, except in the latency test, which counts edges on purpose. The bench never asserts write and read together, and it stays in the 3-bit offset space, so the properties' premises hold.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned REG_ADDR_W = 3;
  typedef logic [REG_ADDR_W-1:0] reg_addr_t;

  // Register offsets; the order is decoded by the read mux and the bench
  localparam reg_addr_t OFS_PIN = 3'd0;
  localparam reg_addr_t OFS_OUT = 3'd1;
  localparam reg_addr_t OFS_DIR = 3'd2;
  localparam reg_addr_t OFS_DEN = 3'd3;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_no = stage_q[1];
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] stable_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q   <= '0;
      stable_q <= '0;
    end else begin
      meta_q   <= async_i;
      stable_q <= meta_q;
    end
  end

  assign sync_o = stable_q;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned      WIDTH    = 8,
  parameter logic [WIDTH-1:0] ANA_MASK = 8'h3C
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  reg_addr_t        addr_i,
  input  logic             we_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] out_q_o,
  output logic [WIDTH-1:0] dir_q_o,
  output logic [WIDTH-1:0] den_q_o
);
  logic             out_en, dir_en, den_en;
  logic [WIDTH-1:0] out_d, dir_d, den_d;
  logic [WIDTH-1:0] out_q, dir_q;

  // Next-state: offset 0 and offset 1 both land in the output data bits
  always_comb begin
    out_en = we_i && ((addr_i == OFS_PIN) || (addr_i == OFS_OUT));
    dir_en = we_i && (addr_i == OFS_DIR);
    den_en = we_i && (addr_i == OFS_DEN);
    out_d  = wdata_i;
    dir_d  = wdata_i;
    den_d  = wdata_i & ANA_MASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= '0;
      dir_q <= '1;
    end else begin
      if (out_en) out_q <= out_d;
      if (dir_en) dir_q <= dir_d;
    end
  end

  // Enable bits exist only for analog-capable pins
  for (genvar g = 0; g < WIDTH; g++) begin : g_den
    if (ANA_MASK[g]) begin : g_cap
      logic bit_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     bit_q <= 1'b0;
        else if (den_en) bit_q <= den_d[g];
      end
      assign den_q_o[g] = bit_q;
    end else begin : g_dig
      assign den_q_o[g] = 1'b0;
    end
  end

  assign out_q_o = out_q;
  assign dir_q_o = dir_q;
endmodule

// File: rtl/gpio_rd_mux.sv
module gpio_rd_mux
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  reg_addr_t        addr_i,
  input  logic             re_i,
  input  logic [WIDTH-1:0] pin_i,
  input  logic [WIDTH-1:0] out_i,
  input  logic [WIDTH-1:0] dir_i,
  input  logic [WIDTH-1:0] den_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] rd_d, rd_q;

  always_comb begin
    unique case (addr_i)
      OFS_PIN: rd_d = pin_i;
      OFS_OUT: rd_d = out_i;
      OFS_DIR: rd_d = dir_i;
      OFS_DEN: rd_d = den_i;
      default: rd_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rd_q <= '0;
    else if (re_i) rd_q <= rd_d;
  end

  assign rdata_o = rd_q;

  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && (addr_i > OFS_DEN)) |=> (rdata_o == '0)); // R9
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o)); // R10
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int unsigned      WIDTH    = 8,
  parameter logic [WIDTH-1:0] ANA_MASK = 8'h3C
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  reg_addr_t        reg_addr_i,
  input  logic             reg_we_i,
  input  logic [WIDTH-1:0] reg_wdata_i,
  input  logic             reg_re_i,
  output logic [WIDTH-1:0] reg_rdata_o,
  input  logic [WIDTH-1:0] pad_in_i,
  output logic [WIDTH-1:0] pad_out_o,
  output logic [WIDTH-1:0] pad_oe_o
);
  localparam logic [WIDTH-1:0] DIG_ONLY = ~ANA_MASK;

  logic             rst_n;
  logic [WIDTH-1:0] pad_sync, out_q, dir_q, den_q, dig_en, pin_val;

  gpio_rst_sync u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n)
  );

  gpio_in_sync #(.WIDTH(WIDTH)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .async_i (pad_in_i),
    .sync_o  (pad_sync)
  );

  gpio_regs #(.WIDTH(WIDTH), .ANA_MASK(ANA_MASK)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .addr_i  (reg_addr_i),
    .we_i    (reg_we_i),
    .wdata_i (reg_wdata_i),
    .out_q_o (out_q),
    .dir_q_o (dir_q),
    .den_q_o (den_q)
  );

  // Digital input buffer gating: analog-capable pins need their enable bit
  assign dig_en  = DIG_ONLY | den_q;
  assign pin_val = pad_sync & dig_en;

  gpio_rd_mux #(.WIDTH(WIDTH)) u_rd (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .addr_i  (reg_addr_i),
    .re_i    (reg_re_i),
    .pin_i   (pin_val),
    .out_i   (out_q),
    .dir_i   (dir_q),
    .den_i   (den_q),
    .rdata_o (reg_rdata_o)
  );

  assign pad_out_o = out_q;
  assign pad_oe_o  = ~dir_q;

  AST_DIR_TO_OE: assert property (@(posedge clk_i) disable iff (!rst_n)
    (reg_we_i && (reg_addr_i == OFS_DIR)) |=> (pad_oe_o == ~$past(reg_wdata_i))); // R2
  AST_WRITE_TO_PAD: assert property (@(posedge clk_i) disable iff (!rst_n)
    (reg_we_i && (reg_addr_i == OFS_PIN || reg_addr_i == OFS_OUT)) |=> (pad_out_o == $past(reg_wdata_i))); // R4
  AST_ANALOG_GATE: assert property (@(posedge clk_i) disable iff (!rst_n)
    (reg_re_i && (reg_addr_i == OFS_PIN)) |=> ((reg_rdata_o & ~$past(dig_en)) == '0)); // R5
  AST_UNMAPPED_WRITE: assert property (@(posedge clk_i) disable iff (!rst_n)
    (reg_we_i && (reg_addr_i > OFS_DEN)) |=> ($stable(pad_out_o) && $stable(pad_oe_o))); // R9
endmodule

// File: tb/gpio_port_ctrl_tb_top.sv
module gpio_port_ctrl_tb_top;
  localparam logic [7:0] MASK = 8'h3C;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic       reg_re = 1'b0;
  logic [7:0] reg_rdata;
  logic [7:0] pad_in = 8'hFF;
  logic [7:0] pad_out, pad_oe;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  gpio_port_ctrl #(.WIDTH(8), .ANA_MASK(MASK)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .reg_addr_i  (reg_addr),
    .reg_we_i    (reg_we),
    .reg_wdata_i (reg_wdata),
    .reg_re_i    (reg_re),
    .reg_rdata_o (reg_rdata),
    .pad_in_i    (pad_in),
    .pad_out_o   (pad_out),
    .pad_oe_o    (pad_oe)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // Tasks start and end at a falling edge
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    reg_addr = a; reg_re = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_re = 1'b0;
    v = reg_rdata;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, held;
    logic [7:0] pats [4];
    pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5; pats[3] = 8'h5A;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check("R1 oe", pad_oe, 8'h00);
    check("R1 out", pad_out, 8'h00);
    check("R1 rdata", reg_rdata, 8'h00);
    rd(3'd1, v); check("R1 out reg", v, 8'h00);
    rd(3'd2, v); check("R1 dir reg", v, 8'hFF);
    rd(3'd3, v); check("R1 den reg", v, 8'h00);
    rd(3'd0, v); check("R5 reset pins gated", v, 8'hFF & ~MASK);

    // R2: direction sweep
    for (int d = 0; d < 256; d++) begin
      wr(3'd2, 8'(d));
      check("R2 oe", pad_oe, ~8'(d));
    end
    wr(3'd2, 8'hFF);

    // R3: output data sweep with readback
    for (int d = 0; d < 256; d++) begin
      wr(3'd1, 8'(d));
      check("R3 pad_out", pad_out, 8'(d));
      rd(3'd1, v); check("R3 readback", v, 8'(d));
    end

    // R4: writes to offset 0 land in output data; offset 0 reads pins
    wr(3'd3, 8'hFF);
    for (int d = 0; d < 256; d += 17) begin
      pad_in = ~8'(d);
      wr(3'd0, 8'(d));
      check("R4 pad_out", pad_out, 8'(d));
      rd(3'd1, v); check("R4 out reg", v, 8'(d));
      settle();
      rd(3'd0, v); check("R4 pin read", v, ~8'(d));
    end

    // R5 R6 R7: sweep every enable pattern against several pad patterns
    for (int c = 0; c < 256; c++) begin
      wr(3'd3, 8'(c));
      rd(3'd3, v); check("R7 den readback", v, 8'(c) & MASK);
      for (int p = 0; p < 4; p++) begin
        pad_in = pats[p];
        settle();
        rd(3'd0, v);
        check("R5 R6 pin gating", v, pats[p] & (~MASK | (8'(c) & MASK)));
      end
    end

    // R8: synchronizer latency
    wr(3'd3, 8'hFF);
    pad_in = 8'h00; settle(); settle();
    pad_in = 8'hB7;
    rd(3'd0, v); check("R8 edge k", v, 8'h00);
    rd(3'd0, v); check("R8 edge k+1", v, 8'h00);
    rd(3'd0, v); check("R8 edge k+2", v, 8'hB7);

    // R9: unmapped offsets
    wr(3'd1, 8'h69); wr(3'd2, 8'h0F); wr(3'd3, 8'h24);
    for (int a = 4; a < 8; a++) begin
      wr(3'(a), 8'hC6);
      rd(3'(a), v); check("R9 unmapped read", v, 8'h00);
      check("R9 pad_out", pad_out, 8'h69);
      check("R9 pad_oe", pad_oe, 8'hF0);
      rd(3'd1, v); check("R9 out reg", v, 8'h69);
      rd(3'd2, v); check("R9 dir reg", v, 8'h0F);
      rd(3'd3, v); check("R9 den reg", v, 8'h24);
    end

    // R10: read data holds without a read strobe
    rd(3'd1, held);
    wr(3'd1, 8'h11);
    wr(3'd2, 8'hEE);
    pad_in = 8'h3C; settle();
    check("R10 hold", reg_rdata, held);
    rd(3'd1, v); check("R10 new capture", v, 8'h11);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule